// File: doc/BRIEF.md
# Eight-Channel Timer Register Bank

This block is the register front end for a group of eight down-counting timer channels. A simple word bus (valid, write, address, data) reaches four 32-bit words per channel: the live count, the reload value and two match thresholds. It also reaches one shared control word and one interrupt status word. The channels themselves sit outside the block. They receive their reload and match values and a 4-bit configuration. A one-cycle strobe carries a count overwrite, and each channel returns its live count and an event pulse.

The address map is not contiguous. The first three channels sit below the control word. The remaining five sit in a second window that starts one 16-byte slot above it. A change to the control word does not reach a channel all at once when its enable bit flips. A channel being switched off loses its enable first and takes its new settings one cycle later. A channel being switched on takes its new settings first and its enable one cycle later. The interrupt status word collects event pulses and is cleared by an AND-mask write.

Top module: `multi_timer_regbank`

## Requirements
- R1: Channel k (0-based) has its base at k*0x10 for k < 3 and at 0x40 + (k-3)*0x10 for k >= 3. The words are base+0x0 count, +0x4 reload, +0x8 match A and +0xC match B. A read returns its data on `bus_rdata` in the cycle after the access. Reload and match words read back what was written.
- R2: A write to a reload or match word appears on that channel's `ch_reload`, `ch_match_a` or `ch_match_b` slice in the cycle after the write.
- R3: A write to a count word raises only that channel's `ch_count_wr` bit for exactly one cycle, the cycle after the write, with the data on `ch_count_wdata`. A read of a count word returns that channel's `ch_count_in` slice.
- R4: The control word sits at 0x30. Channel k owns bits [4k+3:4k], where bit 0 is enable, bit 1 is external clock select, bit 2 is overflow interrupt enable and bit 3 is pulse enable. A read returns the value last written.
- R5: When a control write clears a channel's enable bit, that channel's `ch_cfg` nibble shows enable 0 with its old other bits in the cycle after the write. It shows the new nibble one cycle later.
- R6: When a control write sets a channel's enable bit, the nibble shows the new other bits with enable 0 in the cycle after the write. The enable rises one cycle later.
- R7: When a control write leaves a channel's enable bit unchanged, the new nibble appears on `ch_cfg` in the cycle after the write.
- R8: The pulse enable bit has no effect on channels 0 to 3: their `ch_cfg` bit 3 stays 0 whatever is written.
- R9: The status word sits at 0x34, with bit k for channel k. A `ch_event[k]` pulse sets bit k in the next cycle and the bit holds. A write keeps only the bits also set in the data, and an event in the same cycle as the write still sets its bit. `irq_status` shows the word.
- R10: An access whose address bits [1:0] are not zero is ignored: it changes no state and reads 0.
- R11: Offsets 0x38, 0x3C and 0x90 and above read 0, and writes to them change nothing.
- R12: After reset, the control word, the status word and all reload and match words are 0, and `ch_cfg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | AW (8) | Byte offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, one cycle after the access |
| ch_cfg | output | NT*4 (32) | Applied per-channel configuration nibbles |
| ch_reload | output | NT*DW (256) | Per-channel reload values |
| ch_match_a | output | NT*DW (256) | Per-channel first match values |
| ch_match_b | output | NT*DW (256) | Per-channel second match values |
| ch_count_wr | output | NT (8) | One-cycle count overwrite strobes |
| ch_count_wdata | output | DW (32) | Count overwrite data |
| ch_count_in | input | NT*DW (256) | Live count from each channel |
| ch_event | input | NT (8) | Interrupt event pulse from each channel |
| irq_status | output | NT (8) | Interrupt status bits |

## Verification
Every result of this block is registered once, so most effects are due one cycle after the edge that samples the access. This covers read data, channel values, count strobes and status bits. The one exception is a control write that flips an enable. It settles over two cycles, with an intermediate nibble in the first. The bench drives inputs on the falling edge and samples on the falling edge after the sampling rising edge. For enable changes it samples both the intermediate nibble and the final nibble one falling edge later. Count strobes are checked at the cycle they are due and again one cycle later to confirm they last a single cycle.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;

    typedef enum logic [1:0] {
        WSEL_COUNT   = 2'd0,
        WSEL_RELOAD  = 2'd1,
        WSEL_MATCH_A = 2'd2,
        WSEL_MATCH_B = 2'd3
    } word_sel_e;

    localparam int unsigned SLOT_BYTES = 16;
    localparam int unsigned NIB_W      = 4;

endpackage

// File: rtl/tmrbank_dec.sv
module tmrbank_dec
    import tmrbank_pkg::*;
#(
    parameter int unsigned AW     = 8,
    parameter int unsigned NT     = 8,
    parameter int unsigned LOW_NT = 3,
    localparam int unsigned IW    = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [AW-1:0] addr,
    output logic          aligned,
    output logic          is_tmr,
    output logic [IW-1:0] idx,
    output word_sel_e     wsel,
    output logic          is_ctrl,
    output logic          is_stat
);
    localparam int unsigned CTRL_OFF = LOW_NT * SLOT_BYTES;
    localparam int unsigned STAT_OFF = CTRL_OFF + 4;
    localparam int unsigned HI_BASE  = CTRL_OFF + SLOT_BYTES;
    localparam int unsigned HI_END   = HI_BASE + (NT - LOW_NT) * SLOT_BYTES;
    localparam logic [AW-5:0] ONE    = 1;

    logic [31:0]   addr_ext;
    logic [AW-5:0] slot;

    assign addr_ext = 32'(addr);
    assign slot     = addr[AW-1:4];
    assign aligned  = (addr[1:0] == 2'b00);
    assign wsel     = word_sel_e'(addr[3:2]);

    always_comb begin
        is_tmr  = 1'b0;
        idx     = '0;
        is_ctrl = 1'b0;
        is_stat = 1'b0;
        if (addr_ext < CTRL_OFF) begin
            is_tmr = 1'b1;
            idx    = IW'(slot);
        end else if (addr_ext >= HI_BASE && addr_ext < HI_END) begin
            is_tmr = 1'b1;
            idx    = IW'(slot - ONE);
        end else if (addr_ext == CTRL_OFF) begin
            is_ctrl = 1'b1;
        end else if (addr_ext == STAT_OFF) begin
            is_stat = 1'b1;
        end
    end
endmodule

// File: rtl/tmrbank_ctrlseq.sv
module tmrbank_ctrlseq
    import tmrbank_pkg::*;
#(
    parameter int unsigned NT          = 8,
    parameter int unsigned PULSE_FIRST = 4,
    localparam int unsigned CW         = NT * NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] ctrl_rd,
    output logic [CW-1:0] cfg
);
    typedef struct packed {
        logic [CW-1:0] ctrl;
        logic [CW-1:0] cfg;
        logic          pend;
    } seq_t;

    seq_t          st_q;
    seq_t          st_d;
    logic [CW-1:0] stage_cfg;
    logic [CW-1:0] final_cfg;

    for (genvar i = 0; i < NT; i++) begin : g_chan
        localparam logic [3:0] KEEP = (i >= PULSE_FIRST) ? 4'hF : 4'h7;
        logic [3:0] old_n;
        logic [3:0] new_n;
        assign old_n = st_q.cfg[NIB_W*i +: NIB_W];
        assign new_n = wdata[NIB_W*i +: NIB_W] & KEEP;
        // enable flips are split from the other bits: off first, on last
        assign stage_cfg[NIB_W*i +: NIB_W] =
            (old_n[0] != new_n[0]) ? (new_n[0] ? {new_n[3:1], 1'b0}
                                                : {old_n[3:1], 1'b0})
                                   : new_n;
        assign final_cfg[NIB_W*i +: NIB_W] = st_q.ctrl[NIB_W*i +: NIB_W] & KEEP;
    end

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.ctrl = wdata;
            st_d.cfg  = stage_cfg;
            st_d.pend = 1'b1;
        end else if (st_q.pend) begin
            st_d.cfg  = final_cfg;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_rd = st_q.ctrl;
    assign cfg     = st_q.cfg;
endmodule

// File: rtl/multi_timer_regbank.sv
module multi_timer_regbank
    import tmrbank_pkg::*;
#(
    parameter int unsigned AW          = 8,
    parameter int unsigned DW          = 32,
    parameter int unsigned NT          = 8,
    parameter int unsigned LOW_NT      = 3,
    parameter int unsigned PULSE_FIRST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic [NT*4-1:0]  ch_cfg,
    output logic [NT*DW-1:0] ch_reload,
    output logic [NT*DW-1:0] ch_match_a,
    output logic [NT*DW-1:0] ch_match_b,
    output logic [NT-1:0]    ch_count_wr,
    output logic [DW-1:0]    ch_count_wdata,
    input  logic [NT*DW-1:0] ch_count_in,
    input  logic [NT-1:0]    ch_event,
    output logic [NT-1:0]    irq_status
);
    localparam int unsigned IW = (NT > 1) ? $clog2(NT) : 1;
    localparam int unsigned CW = NT * NIB_W;

    typedef struct packed {
        logic [NT-1:0][DW-1:0] reload;
        logic [NT-1:0][DW-1:0] match_a;
        logic [NT-1:0][DW-1:0] match_b;
        logic [DW-1:0]         rdata;
        logic [NT-1:0]         cnt_wr;
        logic [DW-1:0]         cnt_wdata;
        logic [NT-1:0]         stat;
    } bank_t;

    bank_t         bk_q;
    bank_t         bk_d;
    logic          dec_aligned;
    logic          dec_tmr;
    logic [IW-1:0] dec_idx;
    word_sel_e     dec_wsel;
    logic          dec_ctrl;
    logic          dec_stat;
    logic          acc_wr;
    logic          acc_rd;
    logic [CW-1:0] ctrl_rd;

    tmrbank_dec #(.AW(AW), .NT(NT), .LOW_NT(LOW_NT)) u_dec (
        .addr    (bus_addr),
        .aligned (dec_aligned),
        .is_tmr  (dec_tmr),
        .idx     (dec_idx),
        .wsel    (dec_wsel),
        .is_ctrl (dec_ctrl),
        .is_stat (dec_stat)
    );

    assign acc_wr = bus_valid && dec_aligned &&  bus_write;
    assign acc_rd = bus_valid && dec_aligned && !bus_write;

    tmrbank_ctrlseq #(.NT(NT), .PULSE_FIRST(PULSE_FIRST)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (acc_wr && dec_ctrl),
        .wdata   (bus_wdata[CW-1:0]),
        .ctrl_rd (ctrl_rd),
        .cfg     (ch_cfg)
    );

    always_comb begin
        bk_d        = bk_q;
        bk_d.cnt_wr = '0;
        bk_d.rdata  = '0;

        if (acc_wr && dec_stat) bk_d.stat = bk_q.stat & bus_wdata[NT-1:0];
        bk_d.stat = bk_d.stat | ch_event;

        if (acc_wr && dec_tmr) begin
            case (dec_wsel)
                WSEL_COUNT: begin
                    bk_d.cnt_wr[dec_idx] = 1'b1;
                    bk_d.cnt_wdata       = bus_wdata;
                end
                WSEL_RELOAD:  bk_d.reload[dec_idx]  = bus_wdata;
                WSEL_MATCH_A: bk_d.match_a[dec_idx] = bus_wdata;
                default:      bk_d.match_b[dec_idx] = bus_wdata;
            endcase
        end

        if (acc_rd) begin
            if (dec_tmr) begin
                case (dec_wsel)
                    WSEL_COUNT:   bk_d.rdata = ch_count_in[dec_idx*DW +: DW];
                    WSEL_RELOAD:  bk_d.rdata = bk_q.reload[dec_idx];
                    WSEL_MATCH_A: bk_d.rdata = bk_q.match_a[dec_idx];
                    default:      bk_d.rdata = bk_q.match_b[dec_idx];
                endcase
            end else if (dec_ctrl) begin
                bk_d.rdata = DW'(ctrl_rd);
            end else if (dec_stat) begin
                bk_d.rdata = DW'(bk_q.stat);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign bus_rdata      = bk_q.rdata;
    assign ch_reload      = bk_q.reload;
    assign ch_match_a     = bk_q.match_a;
    assign ch_match_b     = bk_q.match_b;
    assign ch_count_wr    = bk_q.cnt_wr;
    assign ch_count_wdata = bk_q.cnt_wdata;
    assign irq_status     = bk_q.stat;
endmodule

// File: rtl/tmrbank_chk.sv
module tmrbank_chk #(
    parameter int unsigned AW     = 8,
    parameter int unsigned NT     = 8,
    parameter int unsigned LOW_NT = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_valid,
    input logic            bus_write,
    input logic [AW-1:0]   bus_addr,
    input logic [NT*4-1:0] ch_cfg,
    input logic [NT-1:0]   ch_count_wr,
    input logic [NT-1:0]   ch_event,
    input logic [NT-1:0]   irq_status
);
    localparam logic [AW-1:0] STAT_ADDR = AW'(LOW_NT * 16 + 4);

    logic stat_wr;
    assign stat_wr = bus_valid && bus_write && (bus_addr == STAT_ADDR);

    for (genvar i = 0; i < NT; i++) begin : g_seq
        // R5 / R6: an enable edge never coincides with other-bit changes
        a_r5_enable_alone: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_cfg[4*i] != $past(ch_cfg[4*i]))
            |-> (ch_cfg[4*i+3 -: 3] == $past(ch_cfg[4*i+3 -: 3])));
    end

    a_r3_count_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_count_wr));

    a_r10_misaligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[1:0] != 2'b00) |=> (ch_count_wr == '0));

    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((irq_status & $past(irq_status)) == $past(irq_status)));

    a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_event != '0) |=> ((irq_status & $past(ch_event)) == $past(ch_event)));
endmodule

bind multi_timer_regbank tmrbank_chk #(.AW(AW), .NT(NT), .LOW_NT(LOW_NT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .ch_cfg      (ch_cfg),
    .ch_count_wr (ch_count_wr),
    .ch_event    (ch_event),
    .irq_status  (irq_status)
);

// File: tb/multi_timer_regbank_tb.sv
`timescale 1ns/1ps
module multi_timer_regbank_tb;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NT = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [DW-1:0]    bus_wdata = '0;
    logic [DW-1:0]    bus_rdata;
    logic [NT*4-1:0]  ch_cfg;
    logic [NT*DW-1:0] ch_reload;
    logic [NT*DW-1:0] ch_match_a;
    logic [NT*DW-1:0] ch_match_b;
    logic [NT-1:0]    ch_count_wr;
    logic [DW-1:0]    ch_count_wdata;
    logic [NT*DW-1:0] ch_count_in = '0;
    logic [NT-1:0]    ch_event = '0;
    logic [NT-1:0]    irq_status;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    multi_timer_regbank u_dut (.*);

    function automatic logic [AW-1:0] base_of(int k);
        return (k < 3) ? AW'(k * 16) : AW'(8'h40 + (k - 3) * 16);
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [AW-1:0] a, logic [DW-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        check("R12 cfg", DW'(ch_cfg), 0);
        check("R12 reload", ch_reload[DW-1:0], 0);
        check("R12 status", DW'(irq_status), 0);
        bus_rd(8'h30, d); check("R12 ctrl read", d, 0);
        bus_rd(8'h84, d); check("R12 reload read", d, 0);
    endtask

    task automatic t_regs();
        logic [DW-1:0] d;
        int ks[4] = '{0, 2, 3, 7};
        foreach (ks[j]) begin
            int k = ks[j];
            bus_wr(base_of(k) + 8'h4, 32'hA000_0000 + k);
            check("R2 reload out", ch_reload[k*DW +: DW], 32'hA000_0000 + k);
            bus_wr(base_of(k) + 8'h8, 32'hB000_0000 + k);
            check("R2 match_a out", ch_match_a[k*DW +: DW], 32'hB000_0000 + k);
            bus_wr(base_of(k) + 8'hC, 32'hC000_0000 + k);
            check("R2 match_b out", ch_match_b[k*DW +: DW], 32'hC000_0000 + k);
        end
        foreach (ks[j]) begin
            int k = ks[j];
            bus_rd(base_of(k) + 8'h4, d); check("R1 reload read", d, 32'hA000_0000 + k);
            bus_rd(base_of(k) + 8'hC, d); check("R1 match_b read", d, 32'hC000_0000 + k);
        end
    endtask

    task automatic t_count();
        logic [DW-1:0] d;
        for (int k = 0; k < NT; k++) ch_count_in[k*DW +: DW] = 32'h5500_0000 + k;
        bus_rd(base_of(5), d); check("R3 count read ch5", d, 32'h5500_0005);
        bus_rd(base_of(1), d); check("R3 count read ch1", d, 32'h5500_0001);
        bus_wr(base_of(6), 32'h1234_5678);
        check("R3 strobe", DW'(ch_count_wr), 32'h40);
        check("R3 data", ch_count_wdata, 32'h1234_5678);
        @(negedge clk);
        check("R3 strobe one cycle", DW'(ch_count_wr), 0);
    endtask

    task automatic t_ctrl();
        logic [DW-1:0] d;
        // R6 enable ch0 and ch4 with all bits set; ch0 pulse is masked (R8)
        bus_wr(8'h30, 32'h000F_000F);
        check("R6 stage ch0", DW'(ch_cfg[3:0]), 32'h6);
        check("R6 stage ch4", DW'(ch_cfg[19:16]), 32'hE);
        @(negedge clk);
        check("R6 final ch0 (R8 pulse masked)", DW'(ch_cfg[3:0]), 32'h7);
        check("R6 final ch4", DW'(ch_cfg[19:16]), 32'hF);
        bus_rd(8'h30, d); check("R4 ctrl read", d, 32'h000F_000F);
        // R5 disable ch0; R7 ch4 keeps enable, changes other bits
        bus_wr(8'h30, 32'h0001_0008);
        check("R5 stage ch0", DW'(ch_cfg[3:0]), 32'h6);
        check("R7 ch4 immediate", DW'(ch_cfg[19:16]), 32'h1);
        @(negedge clk);
        check("R5 final ch0", DW'(ch_cfg[3:0]), 32'h0);
        check("R7 ch4 held", DW'(ch_cfg[19:16]), 32'h1);
        // R8 pulse only on ch3: masked; R7 no enable change
        bus_wr(8'h30, 32'h0001_8000);
        @(negedge clk);
        check("R8 ch3 pulse no effect", DW'(ch_cfg[15:12]), 32'h0);
        bus_rd(8'h30, d); check("R4 ctrl read 2", d, 32'h0001_8000);
    endtask

    task automatic t_status();
        logic [DW-1:0] d;
        ch_event = 8'h05;
        @(negedge clk);
        ch_event = 8'h00;
        check("R9 event set", DW'(irq_status), 32'h05);
        @(negedge clk);
        check("R9 held", DW'(irq_status), 32'h05);
        bus_rd(8'h34, d); check("R9 read", d, 32'h05);
        ch_event = 8'h02;
        bus_wr(8'h34, 32'h04);
        ch_event = 8'h00;
        check("R9 and plus event", DW'(irq_status), 32'h06);
        bus_wr(8'h34, 32'h0);
        check("R9 cleared", DW'(irq_status), 32'h0);
    endtask

    task automatic t_unaligned();
        logic [DW-1:0] d;
        logic [NT*4-1:0] cfg0 = ch_cfg;
        bus_wr(base_of(0) + 8'h5, 32'hDEAD_BEEF);
        check("R10 reload unchanged", ch_reload[DW-1:0], 32'hA000_0000);
        bus_wr(8'h31, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R10 cfg unchanged", DW'(ch_cfg), DW'(cfg0));
        bus_wr(base_of(2) + 8'h2, 32'h1);
        check("R10 no strobe", DW'(ch_count_wr), 0);
        bus_rd(base_of(0) + 8'h5, d); check("R10 read zero", d, 0);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] d;
        logic [NT*4-1:0]  cfg0 = ch_cfg;
        logic [NT*DW-1:0] rl0 = ch_reload;
        logic [NT*DW-1:0] ma0 = ch_match_a;
        logic [NT*DW-1:0] mb0 = ch_match_b;
        ch_event = 8'h80;
        @(negedge clk);
        ch_event = 8'h00;
        bus_wr(8'h38, 32'hFFFF_FFFF);
        bus_wr(8'h3C, 32'hFFFF_FFFF);
        bus_wr(8'h90, 32'h1111_1111);
        bus_wr(8'hFC, 32'h2222_2222);
        @(negedge clk);
        check("R11 cfg", DW'(ch_cfg), DW'(cfg0));
        check("R11 reload", DW'(ch_reload == rl0), 1);
        check("R11 match", DW'((ch_match_a == ma0) && (ch_match_b == mb0)), 1);
        check("R11 status kept", DW'(irq_status), 32'h80);
        bus_rd(8'h38, d); check("R11 read 38", d, 0);
        bus_rd(8'h3C, d); check("R11 read 3C", d, 0);
        bus_rd(8'h90, d); check("R11 read 90", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_count();
        t_ctrl();
        t_status();
        t_unaligned();
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule